// File: doc/BRIEF.md
# Protection Fault Latch Supervisor

This block sits between a set of protection comparators and the gate driver of a switching power controller. Each protection condition is held through its own debounce timer, counted in microsecond ticks. When a timer expires, gate drive is shut off and stays off until the supply has collapsed. Over-current requests arrive already qualified and trip at once. The first fault to trip is kept as a cause code. An input-line undervoltage (brown-out) condition also stops the gate through its own long timer, but it does not latch.

The controller has three states. `ST_RUN` drives the gate. `ST_BROWN` holds the gate off while line voltage is low. `ST_LATCH` holds the gate off until the supply-release flag is seen. The transitions are:

- `T_TRIP` (from RUN or BROWN to LATCH) on any latching trip.
- `T_BROWN` (RUN to BROWN) when the brown-out timer expires.
- `T_RECOVER` (BROWN to RUN) when the brown-out flag clears.
- `T_RELEASE` (LATCH to RUN) when the release flag is seen.

Top module: `prot_latch_supervisor`

## Requirements
- R1: After reset the gate is enabled (`gate_en`=1) and `fault_cause` is 0.
- R2: `rt_in_window` held true for `OTP_WARM_US` ticks latches with cause 3 (thermal window over-temperature).
- R3: `rt_below_low` held true for `OTP_LOW_US` ticks latches with cause 2 (low pin / external latch request).
- R4: The short-circuit timer runs only while `fb_high` and `vdd_scp_low` are both true. Held for `SCP_US` ticks, it latches with cause 4. One flag alone never trips it.
- R5: `vdd_ovp` held for `OVP_US` ticks latches with cause 1. `fb_open_loop` held for `OLP_US` ticks latches with cause 5.
- R6: `ocp_req` latches with cause 6 on the first clock edge at which it is sampled high.
- R7: A debounce timer counts only ticks seen while its condition is true. It restarts from zero whenever the condition goes false before expiry. A timer trips in the cycle after its count reaches its limit while the condition still holds.
- R8: `fault_cause` keeps the first fault that tripped. Later faults do not change it while latched. When several trips happen in the same cycle, the lowest cause code wins.
- R9: `gate_en` falls on the same clock edge at which `fault_cause` becomes non-zero.
- R10: While latched, only `vdd_release` has any effect. It returns the block to running, with cause 0 and the gate enabled, on the next edge.
- R11: `brown_low` held for `BROWN_US` ticks disables the gate with cause 0. The gate returns on the edge after `brown_low` is sampled low. A latching trip still overrides the brown-out state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rt_in_window | input | 1 | Temperature pin inside the over-temperature window |
| rt_below_low | input | 1 | Temperature pin below the lower threshold |
| fb_high | input | 1 | Feedback above open-loop level (short-circuit leg) |
| vdd_scp_low | input | 1 | Supply below short-circuit threshold |
| vdd_ovp | input | 1 | Supply over-voltage |
| fb_open_loop | input | 1 | Feedback open-loop flag |
| ocp_req | input | 1 | Qualified over-current request |
| brown_low | input | 1 | Line voltage below brown-out level |
| vdd_release | input | 1 | Supply below latch-release level |
| gate_en | output | 1 | Gate drive permitted |
| fault_cause | output | 3 | Latched first-fault code, 0 when none |

## Verification
Directed runs first hold each condition for one tick short of its limit and then drop it. This separates the restart-on-drop behaviour from a true expiry. The same condition is then held to its full limit, which pins down the exact trip cycle. The short-circuit leg is tried with each flag alone and then with both, to show that the two flags combine with AND. Random segments then overlap many conditions with release pulses and brown-out episodes. A cycle-level reference model checks first-fault retention, same-cycle priority and the override of brown-out by a latching trip.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BROWN = 2'd1,
        ST_LATCH = 2'd2
    } sup_state_t;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_OVP    = 3'd1,
        CAUSE_RT_LOW = 3'd2,
        CAUSE_RT_WIN = 3'd3,
        CAUSE_SCP    = 3'd4,
        CAUSE_OLP    = 3'd5,
        CAUSE_OCP    = 3'd6
    } cause_t;

    // debounced latching sources, index i maps to cause code i+1
    localparam int NUM_DB   = 5;
    // all latching sources including the immediate over-current request
    localparam int NUM_TRIP = NUM_DB + 1;

endpackage

// File: rtl/prot_debounce.sv
module prot_debounce #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic trip
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip = cond && (cnt_q == LIM_V);

endmodule

// File: rtl/prot_cause_pick.sv
module prot_cause_pick
    import prot_pkg::*;
#(
    parameter int N = NUM_TRIP
) (
    input  logic [N-1:0]       trips,
    output logic               any_trip,
    output logic [CAUSE_W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (trips[i]) begin
                code = CAUSE_W'(i + 1);
            end
        end
    end

    assign any_trip = |trips;

endmodule

// File: rtl/prot_latch_supervisor.sv
module prot_latch_supervisor
    import prot_pkg::*;
#(
    parameter int unsigned OVP_US      = 10,
    parameter int unsigned OTP_LOW_US  = 165,
    parameter int unsigned OTP_WARM_US = 14000,
    parameter int unsigned SCP_US      = 17000,
    parameter int unsigned OLP_US      = 55000,
    parameter int unsigned BROWN_US    = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick,
    input  logic               rt_in_window,
    input  logic               rt_below_low,
    input  logic               fb_high,
    input  logic               vdd_scp_low,
    input  logic               vdd_ovp,
    input  logic               fb_open_loop,
    input  logic               ocp_req,
    input  logic               brown_low,
    input  logic               vdd_release,
    output logic               gate_en,
    output logic [CAUSE_W-1:0] fault_cause
);
    localparam int unsigned LIM_ARR [NUM_DB] = '{OVP_US, OTP_LOW_US, OTP_WARM_US, SCP_US, OLP_US};

    logic [NUM_DB-1:0]   db_cond;
    logic [NUM_TRIP-1:0] trips;
    logic                any_trip;
    logic [CAUSE_W-1:0]  pick_code;
    logic                brown_trip;

    assign db_cond = {fb_open_loop, (fb_high && vdd_scp_low), rt_in_window, rt_below_low, vdd_ovp};

    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        prot_debounce #(.LIMIT(LIM_ARR[g])) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (us_tick),
            .cond  (db_cond[g]),
            .trip  (trips[g])
        );
    end

    assign trips[NUM_TRIP-1] = ocp_req;

    prot_debounce #(.LIMIT(BROWN_US)) u_brown (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .cond  (brown_low),
        .trip  (brown_trip)
    );

    prot_cause_pick #(.N(NUM_TRIP)) u_pick (
        .trips    (trips),
        .any_trip (any_trip),
        .code     (pick_code)
    );

    sup_state_t         state_q, state_d;
    logic [CAUSE_W-1:0] cause_q, cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_trip) begin            // T_TRIP
                    state_d = ST_LATCH;
                    cause_d = pick_code;
                end else if (brown_trip) begin // T_BROWN
                    state_d = ST_BROWN;
                end
            end
            ST_BROWN: begin
                if (any_trip) begin            // T_TRIP
                    state_d = ST_LATCH;
                    cause_d = pick_code;
                end else if (!brown_low) begin // T_RECOVER
                    state_d = ST_RUN;
                end
            end
            ST_LATCH: begin
                if (vdd_release) begin         // T_RELEASE
                    state_d = ST_RUN;
                    cause_d = '0;
                end
            end
            default: begin
                state_d = ST_LATCH;
                cause_d = CAUSE_W'(CAUSE_OVP);
            end
        endcase
    end

    always_comb begin
        gate_en     = (state_q == ST_RUN);
        fault_cause = cause_q;
    end

endmodule

// File: rtl/prot_latch_checker.sv
module prot_latch_checker
    import prot_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ocp_req,
    input logic               vdd_release,
    input logic               fb_high,
    input logic               vdd_scp_low,
    input logic               gate_en,
    input logic [CAUSE_W-1:0] fault_cause
);
    AST_GATE_OFF_WHEN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cause != '0) |-> !gate_en); // R9

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cause != '0) && !vdd_release) |=> $stable(fault_cause)); // R8

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cause != '0) && vdd_release) |=> (fault_cause == '0)); // R10

    AST_OCP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && ocp_req) |=> (!gate_en && (fault_cause != '0))); // R6

    AST_SCP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cause != CAUSE_W'(CAUSE_SCP)) && !(fb_high && vdd_scp_low))
        |=> (fault_cause != CAUSE_W'(CAUSE_SCP))); // R4

endmodule

bind prot_latch_supervisor prot_latch_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ocp_req     (ocp_req),
    .vdd_release (vdd_release),
    .fb_high     (fb_high),
    .vdd_scp_low (vdd_scp_low),
    .gate_en     (gate_en),
    .fault_cause (fault_cause)
);

// File: tb/prot_latch_supervisor_test.sv
module prot_latch_supervisor_test;

    localparam int L_OVP = 3, L_LOW = 5, L_WARM = 40, L_SCP = 30, L_OLP = 20, L_BROWN = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic rt_in_window = 0, rt_below_low = 0, fb_high = 0, vdd_scp_low = 0;
    logic vdd_ovp = 0, fb_open_loop = 0, ocp_req = 0, brown_low = 0, vdd_release = 0;
    logic       gate_en;
    logic [2:0] fault_cause;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prot_latch_supervisor #(
        .OVP_US(L_OVP), .OTP_LOW_US(L_LOW), .OTP_WARM_US(L_WARM),
        .SCP_US(L_SCP), .OLP_US(L_OLP), .BROWN_US(L_BROWN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .rt_in_window(rt_in_window), .rt_below_low(rt_below_low),
        .fb_high(fb_high), .vdd_scp_low(vdd_scp_low), .vdd_ovp(vdd_ovp),
        .fb_open_loop(fb_open_loop), .ocp_req(ocp_req), .brown_low(brown_low),
        .vdd_release(vdd_release), .gate_en(gate_en), .fault_cause(fault_cause)
    );

    function automatic int lim_of(int k);
        case (k)
            0: return L_OVP;
            1: return L_LOW;
            2: return L_WARM;
            3: return L_SCP;
            default: return L_OLP;
        endcase
    endfunction

    function automatic logic cond_of(int k);
        case (k)
            0: return vdd_ovp;
            1: return rt_below_low;
            2: return rt_in_window;
            3: return fb_high && vdd_scp_low;
            default: return fb_open_loop;
        endcase
    endfunction

    // reference model, built from the requirements
    int   m_cnt [5];
    int   m_bcnt;
    int   m_cause;
    logic m_brown;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) m_cnt[k] <= 0;
            m_bcnt  <= 0;
            m_cause <= 0;
            m_brown <= 1'b0;
        end else begin
            int code;
            logic btrip;
            code = 0;
            for (int k = 4; k >= 0; k--)
                if (cond_of(k) && m_cnt[k] == lim_of(k)) code = k + 1;
            if (code == 0 && ocp_req) code = 6;
            btrip = brown_low && (m_bcnt == L_BROWN);
            for (int k = 0; k < 5; k++) begin
                if (!cond_of(k)) m_cnt[k] <= 0;
                else if (us_tick && m_cnt[k] < lim_of(k)) m_cnt[k] <= m_cnt[k] + 1;
            end
            if (!brown_low) m_bcnt <= 0;
            else if (us_tick && m_bcnt < L_BROWN) m_bcnt <= m_bcnt + 1;
            if (m_cause != 0) begin
                if (vdd_release) m_cause <= 0;
            end else if (code != 0) begin
                m_cause <= code;
                m_brown <= 1'b0;
            end else if (m_brown) begin
                if (!brown_low) m_brown <= 1'b0;
            end else if (btrip) begin
                m_brown <= 1'b1;
            end
        end
    end

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        us_tick <= (tdiv == 3);
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic exp_g;
            exp_g = (m_cause == 0) && !m_brown;
            n_cmp++;
            if (gate_en !== exp_g || fault_cause !== 3'(m_cause)) begin
                n_bad++;
                $display("FAIL %s: gate_en=%0b cause=%0d expected gate_en=%0b cause=%0d (cycle %0d)",
                         cur_req, gate_en, fault_cause, exp_g, m_cause, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        rt_in_window = 0; rt_below_low = 0; fb_high = 0; vdd_scp_low = 0;
        vdd_ovp = 0; fb_open_loop = 0; ocp_req = 0; brown_low = 0; vdd_release = 0;
    endtask

    task automatic release_pulse();
        clear_all();
        wait_cyc(2);
        vdd_release = 1; wait_cyc(1); vdd_release = 0;
        wait_cyc(3);
    endtask

    initial begin
        void'($urandom(32'd4242));
        wait_cyc(3);
        chk_on = 1'b1;               // R1: reset state compared while held
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(5);

        // R7: window held one tick short, then dropped; no trip
        cur_req = "R7";
        rt_in_window = 1; wait_cyc(4 * (L_WARM - 1)); rt_in_window = 0; wait_cyc(4);
        rt_in_window = 1; wait_cyc(4 * (L_WARM - 1)); rt_in_window = 0; wait_cyc(8);
        // R2: full hold
        cur_req = "R2";
        rt_in_window = 1; wait_cyc(4 * L_WARM + 8);
        // R8: later faults ignored while latched
        cur_req = "R8";
        ocp_req = 1; vdd_ovp = 1; wait_cyc(20);
        cur_req = "R10";
        release_pulse();

        cur_req = "R3";
        rt_below_low = 1; wait_cyc(4 * L_LOW + 8);
        release_pulse();

        // R4: single flags alone, then both
        cur_req = "R4";
        fb_high = 1; wait_cyc(4 * L_SCP + 8); fb_high = 0;
        vdd_scp_low = 1; wait_cyc(4 * L_SCP + 8);
        fb_high = 1; wait_cyc(4 * L_SCP + 8);
        release_pulse();

        cur_req = "R5";
        vdd_ovp = 1; wait_cyc(4 * L_OVP + 8);
        release_pulse();
        fb_open_loop = 1; wait_cyc(4 * L_OLP + 8);
        release_pulse();

        cur_req = "R6";
        ocp_req = 1; wait_cyc(1); ocp_req = 0; wait_cyc(5);
        release_pulse();

        // R9: drop edge compared every cycle; vdd_ovp with ocp at same time
        cur_req = "R9";
        vdd_ovp = 1; ocp_req = 1; wait_cyc(10);
        release_pulse();

        cur_req = "R11";
        brown_low = 1; wait_cyc(4 * L_BROWN + 12);
        brown_low = 0; wait_cyc(6);
        brown_low = 1; wait_cyc(4 * L_BROWN + 12);
        rt_below_low = 1; wait_cyc(4 * L_LOW + 8);
        release_pulse();

        // random overlap of conditions, checked by the model
        cur_req = "R8";
        for (int s = 0; s < 1800; s++) begin
            rt_in_window = ($urandom % 4) == 0;
            rt_below_low = ($urandom % 8) == 0;
            fb_high      = ($urandom % 2) == 0;
            vdd_scp_low  = ($urandom % 2) == 0;
            vdd_ovp      = ($urandom % 10) == 0;
            fb_open_loop = ($urandom % 5) == 0;
            ocp_req      = ($urandom % 30) == 0;
            brown_low    = ($urandom % 3) == 0;
            vdd_release  = ($urandom % 12) == 0;
            wait_cyc(1 + ($urandom % 40));
        end
        clear_all();
        wait_cyc(10);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule